// File: doc/BRIEF.md
# ADC Serial Readout State Controller

This block is the digital state keeper behind a converter's four-wire serial port. It walks through three working states: converting, asleep with a result held, and shifting that result out. The host watches and drives these states using only an active-low chip select and a serial clock. When chip select is low and no readout is under way, the data pin shows a busy flag. It reads 1 while a conversion runs and 0 once a result is waiting.

A readout begins on the first serial clock rising edge seen while the block is asleep and selected. The 32-bit result then leaves MSB first, one bit per serial clock falling edge. After the last bit the block starts a new conversion on its own. If chip select rises at any point after the readout has begun, the transfer stops and a new conversion starts.

The serial clock level is sampled on every chip select falling edge. A high level there means the host expects an internally clocked mode that this block does not provide. The block then raises a one-cycle error pulse and parks until chip select falls again with the serial clock low.

Each result word comes from a stub conversion stage over a valid/ready pair. Ready is high only once the conversion time has elapsed. While valid stays low, the block keeps converting and keeps showing busy, so the result source applies back-pressure simply by withholding valid.

Top module: `adc_readout_ctrl`

## Requirements
- R1: Whenever chip select has been high for at least three system clocks, `sdo_oe_o` is 0.
- R2: With chip select low and no readout started, `sdo_o` is 1 during conversion and 0 while asleep.
- R3: `res_ready_o` rises CONV_CYCLES clocks into a conversion and stays high until `res_valid_i` is seen. The word is taken on the cycle both are high, and the block then sleeps whatever the chip select level.
- R4: A chip select falling edge with the serial clock high gives exactly one `err_o` pulse and parks the block with the output disabled and no conversion. A later falling edge with the serial clock low starts a conversion.
- R5: A serial clock rising edge starts a readout only while the block is asleep and selected; rising edges during conversion leave the busy flag at 1.
- R6: During a readout, the first serial clock falling edge puts result bit 31 on `sdo_o`, and each later falling edge puts out the next lower bit, down to bit 0.
- R7: The falling edge after bit 0 has been shown ends the readout and starts a conversion, so the busy flag reads 1.
- R8: A chip select rising edge during a readout aborts it and starts a conversion. A rising edge while asleep and before readout keeps the held word intact for a later full readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select from host, active low, asynchronous |
| sck_i | input | 1 | Serial clock from host, asynchronous |
| res_data_i | input | 32 | Conversion result word |
| res_valid_i | input | 1 | Result word is valid |
| res_ready_o | output | 1 | Block can take a result word |
| sdo_o | output | 1 | Serial data / busy flag value |
| sdo_oe_o | output | 1 | Output enable for the serial data pin (0 = high impedance) |
| err_o | output | 1 | One-cycle pulse on internal-clock mode request |

## Verification
A change on `cs_n_i` or `sck_i` passes two synchronizer flops and one edge-detect comparison. The state register therefore takes the change on the third rising clock edge after the pin moves. `sdo_oe_o` follows synchronized chip select after the second edge. The bench moves each pin on a falling clock edge and waits four clock cycles before it samples any output, which lies past every one of these latencies. The result handshake completes one edge after valid meets ready, and the conversion window is waited out with margin before the busy flag is checked.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2,
    ST_HALT  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[g];
        q[g] <= RST_VAL[g];
      end else begin
        meta <= d[g];
        q[g] <= meta;
      end
    end
  end
endmodule

// File: rtl/adc_rd_conv_timer.sv
module adc_rd_conv_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LIMIT);
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= data;
    else if (shift) sreg <= {sreg[W-2:0], 1'b0};
  end

  assign msb = sreg[W-1];
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              res_valid_i,
  output logic              res_ready_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              err_o
);
  localparam int BCW = $clog2(DATA_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  rd_state_e     state;
  logic [1:0]    pins_s;
  logic          cs_s, sck_s, cs_d, sck_d;
  logic          cs_fall, cs_rise, sck_rise, sck_fall;
  logic          conv_done, accept, shown, do_shift, msb;
  logic [BCW-1:0] bcnt;

  adc_rd_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, cs_n_i}), .q(pins_s)
  );
  assign cs_s  = pins_s[0];
  assign sck_s = pins_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_fall  =  cs_d  & ~cs_s;
  assign cs_rise  = ~cs_d  &  cs_s;
  assign sck_rise = ~sck_d &  sck_s;
  assign sck_fall =  sck_d & ~sck_s;

  adc_rd_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_CONV), .done(conv_done)
  );

  assign res_ready_o = conv_done;
  assign accept      = res_valid_i & res_ready_o;
  assign do_shift    = (state == ST_DOUT) & sck_fall & shown & ~cs_rise
                       & (bcnt != LAST_BIT);

  adc_rd_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .data(res_data_i),
    .shift(do_shift), .msb(msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CONV;
      shown <= 1'b0;
      bcnt  <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (cs_fall && sck_s) begin
        state <= ST_HALT;
        err_o <= 1'b1;
      end else if (cs_fall && state == ST_HALT) begin
        state <= ST_CONV;
      end else begin
        unique case (state)
          ST_CONV:  if (accept) state <= ST_SLEEP;
          ST_SLEEP: if (!cs_s && sck_rise) begin
                      state <= ST_DOUT;
                      shown <= 1'b0;
                      bcnt  <= '0;
                    end
          ST_DOUT: begin
            if (cs_rise) begin
              state <= ST_CONV;
            end else if (sck_fall) begin
              if (!shown)                shown <= 1'b1;
              else if (bcnt == LAST_BIT) state <= ST_CONV;
              else                       bcnt  <= bcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_CONV:  sdo_o = 1'b1;
      ST_DOUT:  sdo_o = shown & msb;
      default:  sdo_o = 1'b0;
    endcase
  end

  assign sdo_oe_o = ~cs_s & (state != ST_HALT);
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk
  import adc_rd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_i,
  input logic       res_valid_i,
  input logic       res_ready_o,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input logic       err_o,
  input logic [1:0] state,
  input logic       cs_rise
);
  AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2)) |-> !sdo_oe_o); // R1

  AST_BUSY_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready_o && sdo_oe_o) |-> sdo_o); // R2

  AST_SLEEP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_i && res_ready_o) |=> (state == ST_SLEEP)); // R3

  AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o); // R4

  AST_ERR_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (state == ST_HALT)); // R4

  AST_DOUT_ONLY_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOUT && $past(state) != ST_DOUT) |-> ($past(state) == ST_SLEEP)); // R5

  AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOUT && cs_rise) |=> (state == ST_CONV)); // R8
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .res_valid_i(res_valid_i),
  .res_ready_o(res_ready_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .err_o(err_o), .state(state), .cs_rise(cs_rise)
);

// File: tb/adc_readout_ctrl_tb_top.sv
module adc_readout_ctrl_tb_top;
  localparam int DATA_W = 32;
  localparam int CONV   = 40;
  localparam int CONV_WAIT = CONV + 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic [DATA_W-1:0] rdata = '0;
  logic rvalid = 1'b0;
  logic rready, sdo, sdo_oe, err;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  adc_readout_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck),
    .res_data_i(rdata), .res_valid_i(rvalid), .res_ready_o(rready),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .err_o(err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(output logic [31:0] w);
    w = '0;
    sck = 1'b1; tick(4);
    for (int i = 0; i < DATA_W; i++) begin
      sck = 1'b0; tick(4);
      w[DATA_W-1-i] = sdo;
      sck = 1'b1; tick(4);
    end
    sck = 1'b0; tick(4);
  endtask

  task automatic t_reset;
    chk("R1 reset oe", 32'(sdo_oe), 0);
    chk("R4 reset err", 32'(err), 0);
    chk("R3 reset ready", 32'(rready), 0);
  endtask

  task automatic t_busy_and_handshake;
    cs_n = 1'b0; tick(4);
    chk("R2 busy flag while converting", 32'(sdo), 1);
    sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    chk("R5 sck during conversion ignored", 32'(sdo), 1);
    tick(CONV_WAIT);
    chk("R3 ready after conversion time", 32'(rready), 1);
    chk("R3 busy held without valid", 32'(sdo), 1);
    rdata = 32'hA5C3_0F96; rvalid = 1'b1; tick(2);
    chk("R3 ready drops after take", 32'(rready), 0);
    chk("R2 flag low when asleep", 32'(sdo), 0);
  endtask

  task automatic t_full_read;
    logic [31:0] w;
    rdata = 32'h1357_9BDF;
    read_word(w);
    chk("R6 word msb first", w, 32'hA5C3_0F96);
    chk("R7 conversion after last bit", 32'(sdo), 1);
  endtask

  task automatic t_abort;
    tick(CONV_WAIT);
    chk("R2 asleep with new word", 32'(sdo), 0);
    rdata = 32'h0F0F_1234;
    sck = 1'b1; tick(4);
    for (int i = 0; i < 5; i++) begin
      sck = 1'b0; tick(4); sck = 1'b1; tick(4);
    end
    sck = 1'b0; tick(4);
    cs_n = 1'b1; tick(4);
    chk("R1 oe off after deselect", 32'(sdo_oe), 0);
    cs_n = 1'b0; tick(4);
    chk("R8 abort restarts conversion", 32'(sdo), 1);
  endtask

  task automatic t_sleep_hold;
    logic [31:0] w;
    tick(CONV_WAIT);
    chk("R3 sleeps with cs low", 32'(sdo), 0);
    cs_n = 1'b1; tick(4); cs_n = 1'b0; tick(4);
    chk("R8 deselect in sleep keeps sleep", 32'(sdo), 0);
    rdata = 32'h8000_0001;
    read_word(w);
    chk("R8 held word intact", w, 32'h0F0F_1234);
  endtask

  task automatic t_internal_mode;
    logic [31:0] w;
    int pulses;
    cs_n = 1'b1; tick(4);
    sck = 1'b1; tick(4);
    cs_n = 1'b0;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (err) pulses++;
    end
    chk("R4 one error pulse", 32'(pulses), 1);
    chk("R4 output parked", 32'(sdo_oe), 0);
    tick(CONV_WAIT);
    chk("R4 no conversion while parked", 32'(rready), 0);
    cs_n = 1'b1; tick(4);
    sck = 1'b0; tick(4);
    cs_n = 1'b0; tick(4);
    chk("R4 restart oe", 32'(sdo_oe), 1);
    chk("R4 restart busy", 32'(sdo), 1);
    tick(CONV_WAIT);
    chk("R2 asleep after restart", 32'(sdo), 0);
    read_word(w);
    chk("R6 word after restart", w, 32'h8000_0001);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_busy_and_handshake();
    t_full_read();
    t_abort();
    t_sleep_hold();
    t_internal_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule